// File: doc/BRIEF.md
# I2C Slave Address Matcher Receiver

This block is the receive side of an I2C slave. It samples the bus clock and data lines, finds START and STOP conditions, and treats the first byte after every START as an address. The upper seven bits of that byte are compared with a programmed own address. The block also recognises the all-zero general call address. When either one matches, a status flag is set and a one-cycle interrupt request is raised. When neither matches, the rest of the transfer is ignored.

After a matched address, and after each data byte that follows, the block holds SCL low. The host reads the received byte and then writes the data register; the write value is a dummy and only releases the bus. A mode input selects whether the block drives an acknowledge on a ninth clock, or whether the byte stream runs with no acknowledge clock at all. A STOP condition ends the transfer. A START condition begins a new address phase.

Top module: `i2c_addr_rx`

## Requirements
- R1: After reset, scl_oe, sda_oe, own_hit, gcall_hit and irq are 0 and rx_byte is 0.
- R2: When the upper seven bits of the address byte equal own_addr and are not all zero, own_hit becomes 1, gcall_hit stays 0, irq pulses for one cycle, rx_byte takes the whole address byte (R/W in bit 0), and scl_oe is 1 once SCL has fallen after the eighth bit.
- R3: When the upper seven bits of the address byte are all zero, gcall_hit becomes 1 and own_hit stays 0. This holds even when own_addr is zero. irq pulses, and SCL is held as in R2.
- R4: When the address matches neither, own_hit and gcall_hit stay 0 and no irq occurs. scl_oe and sda_oe stay 0 and rx_byte is unchanged, and later bytes are ignored until the next START.
- R5: Data bytes after a matched address are shifted MSB first on SCL rising edges. The byte appears on rx_byte together with a one-cycle irq pulse, and SCL is then held low until dat_wr is pulsed.
- R6: With ack_clk_en=1, a dat_wr that releases SCL also drives SDA low (sda_oe=1). SDA stays driven through the ninth clock's high phase and is released after that clock falls. While sda_oe is 1, scl_oe is 0.
- R7: With ack_clk_en=0, sda_oe never asserts. The next rising SCL edge after release carries the MSB of the next byte.
- R8: A STOP (SDA rising while SCL is high) clears own_hit and gcall_hit and releases scl_oe and sda_oe.
- R9: A START (SDA falling while SCL is high), including a repeated START within a transfer, clears both flags and begins a new address phase.
- R10: A dat_wr pulse while SCL is not being held has no effect on the byte being received or on the bus lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr | input | BYTE_W-1 | Programmed seven-bit own address |
| ack_clk_en | input | 1 | 1: acknowledge on a ninth clock; 0: no acknowledge clock |
| dat_wr | input | 1 | One-cycle host write to the data register (dummy, releases SCL) |
| rx_byte | output | BYTE_W | Last accepted byte |
| own_hit | output | 1 | Addressed-as-slave flag |
| gcall_hit | output | 1 | General-call flag |
| irq | output | 1 | One-cycle interrupt request per accepted byte |

## Verification
The bench builds the block with BYTE_W=8 and SYNC_STAGES=2. This is standard byte framing behind a two-flop synchroniser. The bench's bit timing leaves ten clocks per phase, so the synchroniser delay does not change the bit order. Random transfers and directed ones mix own-address, general-call and foreign addresses in both acknowledge modes. They include an own address of zero, a repeated START after a match, and a stray dat_wr in the middle of a byte.

// File: rtl/i2c_arx_pkg.sv
package i2c_arx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_WFALL,
    ST_HOLD,
    ST_ACK,
    ST_SKIP
  } rx_state_e;

  typedef enum logic [1:0] {
    HIT_NONE,
    HIT_OWN,
    HIT_GCALL
  } hit_e;
endpackage

// File: rtl/i2c_arx_sync.sv
module i2c_arx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= d;
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_arx_events.sv
module i2c_arx_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // Data edges count as conditions only while the clock is steadily high.
  assign start_evt = scl_s && scl_q && sda_q && !sda_s;
  assign stop_evt  = scl_s && scl_q && !sda_q && sda_s;
  assign scl_rise  = scl_s && !scl_q;
  assign scl_fall  = !scl_s && scl_q;
endmodule

// File: rtl/i2c_arx_fsm.sv
module i2c_arx_fsm
  import i2c_arx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_bit,
  input  logic [BYTE_W-2:0] own_addr,
  input  logic              ack_clk_en,
  input  logic              dat_wr,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              own_hit,
  output logic              gcall_hit,
  output logic              irq
);
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] next_byte;
  logic              ack_rose;
  hit_e              hit;

  assign next_byte = {shreg[BYTE_W-2:0], sda_bit};

  always_comb begin
    if (next_byte[BYTE_W-1:1] == '0)            hit = HIT_GCALL;
    else if (next_byte[BYTE_W-1:1] == own_addr) hit = HIT_OWN;
    else                                        hit = HIT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      rx_byte   <= '0;
      own_hit   <= 1'b0;
      gcall_hit <= 1'b0;
      irq       <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      ack_rose  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (start_evt) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        shreg     <= '0;
        own_hit   <= 1'b0;
        gcall_hit <= 1'b0;
        scl_oe    <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (stop_evt) begin
        state     <= ST_IDLE;
        own_hit   <= 1'b0;
        gcall_hit <= 1'b0;
        scl_oe    <= 1'b0;
        sda_oe    <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_DATA: begin
            if (scl_rise) begin
              shreg   <= next_byte;
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) begin
                bit_cnt <= '0;
                if (state == ST_DATA) begin
                  rx_byte <= next_byte;
                  irq     <= 1'b1;
                  state   <= ST_WFALL;
                end else if (hit == HIT_NONE) begin
                  state <= ST_SKIP;
                end else begin
                  rx_byte   <= next_byte;
                  irq       <= 1'b1;
                  own_hit   <= (hit == HIT_OWN);
                  gcall_hit <= (hit == HIT_GCALL);
                  state     <= ST_WFALL;
                end
              end
            end
          end
          ST_WFALL: begin
            if (scl_fall) begin
              scl_oe <= 1'b1;
              state  <= ST_HOLD;
            end
          end
          ST_HOLD: begin
            if (dat_wr) begin
              scl_oe  <= 1'b0;
              bit_cnt <= '0;
              if (ack_clk_en) begin
                sda_oe   <= 1'b1;
                ack_rose <= 1'b0;
                state    <= ST_ACK;
              end else begin
                state <= ST_DATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_rise) ack_rose <= 1'b1;
            if (scl_fall && ack_rose) begin
              sda_oe <= 1'b0;
              state  <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: the two flags never read 1 together
  assert_flag_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(own_hit && gcall_hit));

  // R2: an interrupt only ever accompanies a match flag
  assert_irq_needs_hit_R2: assert property (@(posedge clk) disable iff (rst)
    irq |-> (own_hit || gcall_hit));

  // R4: a skipped transfer raises nothing and stretches nothing
  assert_skip_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> (!irq && !scl_oe && !sda_oe && !own_hit && !gcall_hit));

  // R5: the clock stays held until the host writes
  assert_hold_until_write_R5: assert property (@(posedge clk) disable iff (rst)
    (scl_oe && !dat_wr && !start_evt && !stop_evt) |=> scl_oe);

  // R6: the acknowledge is never driven while the clock is stretched
  assert_ack_no_stretch_R6: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> !scl_oe);

  // R8: a STOP drops flags and both drivers
  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (!own_hit && !gcall_hit && !scl_oe && !sda_oe));

  // R9: a START drops both flags
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (!own_hit && !gcall_hit));
endmodule

// File: rtl/i2c_addr_rx.sv
module i2c_addr_rx #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [BYTE_W-2:0] own_addr,
  input  logic              ack_clk_en,
  input  logic              dat_wr,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              own_hit,
  output logic              gcall_hit,
  output logic              irq
);
  logic scl_s, sda_s;
  logic start_evt, stop_evt, scl_rise, scl_fall;

  i2c_arx_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_i), .q(scl_s)
  );

  i2c_arx_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_i), .q(sda_s)
  );

  i2c_arx_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  i2c_arx_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_bit    (sda_s),
    .own_addr   (own_addr),
    .ack_clk_en (ack_clk_en),
    .dat_wr     (dat_wr),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .rx_byte    (rx_byte),
    .own_hit    (own_hit),
    .gcall_hit  (gcall_hit),
    .irq        (irq)
  );

  // R1: the bus is left alone straight after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!scl_oe && !sda_oe && !irq));
endmodule

// File: tb/i2c_addr_rx_test.sv
`timescale 1ns/100ps
module i2c_addr_rx_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, dat_wr = 1'b0, ack_en = 1'b1;
  logic [6:0] own = 7'h2A;
  logic scl_oe, sda_oe, own_hit, gcall_hit, irq;
  logic [7:0] rx_byte;
  logic scl_line, sda_line;
  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_addr_rx uut (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own), .ack_clk_en(ack_en),
    .dat_wr(dat_wr), .rx_byte(rx_byte), .own_hit(own_hit),
    .gcall_hit(gcall_hit), .irq(irq)
  );

  int errors = 0, checks = 0, irq_cnt = 0, sda_cnt = 0;
  bit done = 1'b0;
  logic [7:0] exp_rx = 8'h00;

  always @(posedge clk) if (!rst) begin
    if (irq) irq_cnt++;
    if (sda_oe) sda_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int classify(input logic [7:0] a, input logic [6:0] o);
    if (a[7:1] == 7'd0) return 2;
    if (a[7:1] == o) return 1;
    return 0;
  endfunction

  task automatic bit_out(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; wait (scl_line == 1'b1); tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic byte_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic start_c;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic stop_c;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic pulse_wr;
    dat_wr = 1'b1; tick(1); dat_wr = 1'b0;
  endtask

  task automatic release_byte(input bit ack);
    pulse_wr;
    tick(2);
    chk("R5 release", scl_oe, 0);
    if (ack) begin
      sda_m = 1'b1; tick(Q);
      chk("R6 ack low before clock", sda_line, 0);
      scl_m = 1'b1; wait (scl_line == 1'b1); tick(Q);
      chk("R6 ack low in clock", sda_line, 0);
      scl_m = 1'b0; tick(Q);
      chk("R6 ack released", sda_oe, 0);
    end
  endtask

  task automatic nack_clock;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    chk("R4 no ack", sda_line, 1);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic run_txn(input logic [7:0] addr, input int nbytes, input bit ack);
    int cls, irq0, sda0;
    logic [7:0] d;
    ack_en = ack;
    sda0 = sda_cnt;
    start_c;
    chk("R9 flags clear after start", {own_hit, gcall_hit}, 0);
    irq0 = irq_cnt;
    byte_out(addr);
    cls = classify(addr, own);
    chk("R2 own flag", own_hit, (cls == 1));
    chk("R3 gcall flag", gcall_hit, (cls == 2));
    chk("R4 irq on address", irq_cnt - irq0, (cls != 0) ? 1 : 0);
    chk("R2 stretch after address", scl_oe, (cls != 0));
    if (cls != 0) begin
      exp_rx = addr;
      chk("R2 address byte", rx_byte, exp_rx);
      tick(3 * Q);
      chk("R5 still held", scl_oe, 1);
      release_byte(ack);
      for (int k = 0; k < nbytes; k++) begin
        d = 8'($urandom);
        irq0 = irq_cnt;
        byte_out(d);
        exp_rx = d;
        chk("R5 data byte", rx_byte, exp_rx);
        chk("R5 data irq", irq_cnt - irq0, 1);
        chk("R5 data hold", scl_oe, 1);
        release_byte(ack);
      end
    end else begin
      if (ack) nack_clock;
      for (int k = 0; k < nbytes; k++) begin
        irq0 = irq_cnt;
        byte_out(8'($urandom));
        chk("R4 ignored irq", irq_cnt - irq0, 0);
        chk("R4 ignored stretch", scl_oe, 0);
        chk("R4 ignored data", rx_byte, exp_rx);
        if (ack) nack_clock;
      end
      chk("R4 never acks", sda_cnt - sda0, 0);
    end
    if (!ack) chk("R7 no sda drive", sda_cnt - sda0, 0);
    stop_c;
    tick(Q);
    chk("R8 stop clears", {own_hit, gcall_hit, scl_oe, sda_oe}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, d;
    int irq0;
    void'($urandom(32'd20250125));
    tick(4);
    rst = 1'b0;
    tick(2);
    chk("R1 reset outputs", {scl_oe, sda_oe, own_hit, gcall_hit, irq}, 0);
    chk("R1 reset byte", rx_byte, 0);

    // directed: own address, ACK mode
    run_txn({own, 1'b0}, 2, 1'b1);
    // directed: general call, no-ACK mode
    run_txn(8'h00, 2, 1'b0);
    // directed: foreign address
    run_txn({own ^ 7'h11, 1'b0}, 2, 1'b1);
    // directed: own address zero, general call wins
    own = 7'h00;
    run_txn(8'h00, 1, 1'b1);
    own = 7'h35;

    // directed R10: stray write in the middle of a byte
    ack_en = 1'b0;
    start_c;
    byte_out({own, 1'b0});
    release_byte(1'b0);
    d = 8'hA6;
    for (int i = 7; i >= 0; i--) begin
      bit_out(d[i]);
      if (i == 4) begin
        pulse_wr;
        tick(2);
        chk("R10 stray write no stretch", scl_oe, 0);
      end
    end
    chk("R10 byte intact", rx_byte, d);
    exp_rx = d;
    release_byte(1'b0);
    stop_c;

    // directed R9: repeated start after a match
    ack_en = 1'b1;
    start_c;
    byte_out({own, 1'b0});
    chk("R9 matched first", own_hit, 1);
    release_byte(1'b1);
    start_c;
    chk("R9 repeated start clears", {own_hit, gcall_hit}, 0);
    irq0 = irq_cnt;
    byte_out({own ^ 7'h40, 1'b1});
    chk("R9 new address phase", {own_hit, gcall_hit, scl_oe}, 0);
    chk("R9 no irq", irq_cnt - irq0, 0);
    nack_clock;
    stop_c;
    tick(Q);

    // random transfers
    for (int t = 0; t < 24; t++) begin
      own = 7'($urandom_range(1, 127));
      case ($urandom % 3)
        0: a = {own, 1'($urandom)};
        1: a = {7'd0, 1'($urandom)};
        default: a = 8'($urandom);
      endcase
      run_txn(a, int'($urandom_range(1, 3)), 1'($urandom));
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule